// File: doc/BRIEF.md
# Matrix-Defined Reconfigurable Interconnect Switch

This block sits around one processing element of a two-dimensional array. It carries data words between the wrapper's link lanes and the element's own ports. The wrapper has lanes facing north, east, south and west. The element has its own input and output ports. Which source may ever reach which sink is fixed at elaboration by a connectivity bit matrix. For every sink, the block builds a multiplexer that holds only the sources the matrix permits. Its select width follows from that driver count. Small configuration registers hold the selects, and they can be rewritten while the array runs, so the topology changes without touching the datapath.

Sources are numbered with the link inputs first: lanes of north, then east, south and west, lane 0 first in each direction. The element's outputs follow. Sinks are numbered the same way: the link outputs first, then the element's inputs. The default matrix gives a mesh. Every element output may drive every link output, and every element input may be driven by any link input. Registers are written through a simple address/data/write-enable port.

Top module: `mxsw_switch`

## Requirements
- R1: Matrix bit `i*NSNK + j` set means source i may drive sink j. A sink with two or more permitted drivers outputs the driver picked by its select value s. The drivers are numbered 0, 1, 2 … in increasing source index.
- R2: A sink with exactly one permitted driver follows that source at all times, whatever is written to its address.
- R3: A sink with no permitted driver outputs zero at all times.
- R4: Reset (`rst_n` low, asynchronous) clears every select register. During and after reset, each multi-driver sink shows its lowest-index permitted driver.
- R5: When `cfg_we` is high at a rising edge, `cfg_wdata` is stored into the register of the sink addressed by `cfg_addr`. The new route is visible right after that edge. All other sinks keep their routes.
- R6: With `UNIFORM`=0, each register is ceil(log2(count)) bits wide and keeps only that many low bits of `cfg_wdata`.
- R7: With `UNIFORM`=1, every register is as wide as the largest select width and keeps the full written value.
- R8: A stored select that is equal to or above the sink's driver count makes that sink output zero.
- R9: A write has no effect on any output if it goes to an address of a sink with fewer than two drivers, or to an address at or beyond the sink count.
- R10: Routing is combinational. A change on a permitted source appears on the sink that selects it within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | $clog2(4*LANES+CORE_IN) | Sink index to write |
| cfg_wdata | input | max(1, largest select width) | Select value to store |
| link_in | input | 4*LANES*DW | Link input lanes (N, E, S, W) |
| core_out | input | CORE_OUT*DW | Words produced by the element |
| link_out | output | 4*LANES*DW | Link output lanes (N, E, S, W) |
| core_in | output | CORE_IN*DW | Words delivered to the element |

## Verification
The bench builds two copies with one lane per direction, two element ports each way, and 8-bit words. One copy uses per-sink register widths and the other uses a uniform width. Both use an irregular matrix instead of the mesh default. That matrix gives sinks with zero, one, two, three and six drivers. This brings within reach the hard-wired and idle sinks, out-of-range selects on a three- and six-input multiplexer, and truncation on narrow registers. It also exposes selects on the uniform copy that lie beyond a two-input sink and give zero.

// File: rtl/mxsw_pkg.sv
package mxsw_pkg;

    localparam int MAXM = 4096;
    localparam int MAXS = 64;

    function automatic logic [MAXM-1:0] mesh_matrix(int lanes, int cin, int cout);
        logic [MAXM-1:0] m;
        int nl;
        int nsnk;
        m    = '0;
        nl   = 4 * lanes;
        nsnk = nl + cin;
        for (int i = 0; i < nl; i++)
            for (int j = nl; j < nsnk; j++)
                m[i*nsnk+j] = 1'b1;
        for (int i = nl; i < nl + cout; i++)
            for (int j = 0; j < nl; j++)
                m[i*nsnk+j] = 1'b1;
        return m;
    endfunction

    function automatic logic [MAXS-1:0] column(logic [MAXM-1:0] m, int nsrc, int nsnk, int j);
        logic [MAXS-1:0] c;
        c = '0;
        for (int i = 0; i < nsrc; i++)
            c[i] = m[i*nsnk+j];
        return c;
    endfunction

    function automatic int popcnt(logic [MAXS-1:0] c, int n);
        int cnt;
        cnt = 0;
        for (int i = 0; i < n; i++)
            if (c[i]) cnt++;
        return cnt;
    endfunction

    function automatic int sel_width(int cnt);
        return (cnt <= 1) ? 0 : $clog2(cnt);
    endfunction

    function automatic int nth_driver(logic [MAXS-1:0] c, int n, int k);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            if (c[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return 0;
    endfunction

    function automatic int max_width(logic [MAXM-1:0] m, int nsrc, int nsnk);
        int w;
        int cw;
        w = 0;
        for (int j = 0; j < nsnk; j++) begin
            cw = sel_width(popcnt(column(m, nsrc, nsnk, j), nsrc));
            if (cw > w) w = cw;
        end
        return w;
    endfunction

endpackage

// File: rtl/mxsw_sel_reg.sv
module mxsw_sel_reg #(
    parameter int SW  = 1,
    parameter int IDX = 0,
    parameter int AW  = 1,
    parameter int CW  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic [SW-1:0] sel
);

    typedef struct packed {
        logic [SW-1:0] sel;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (cfg_addr == AW'(IDX)))
            st_d.sel = cfg_wdata[SW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;

endmodule

// File: rtl/mxsw_sink_mux.sv
module mxsw_sink_mux
    import mxsw_pkg::*;
#(
    parameter int              NSRC = 2,
    parameter int              DW   = 8,
    parameter int              SW   = 1,
    parameter logic [MAXS-1:0] COL  = '1
) (
    input  logic [NSRC*DW-1:0] srcs,
    input  logic [SW-1:0]      sel,
    output logic [DW-1:0]      dout
);

    always_comb begin
        int k;
        k    = 0;
        dout = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (COL[i]) begin
                if (k == int'(sel)) dout = srcs[i*DW +: DW];
                k++;
            end
        end
    end

endmodule

// File: rtl/mxsw_switch.sv
module mxsw_switch
    import mxsw_pkg::*;
#(
    parameter int              LANES    = 2,
    parameter int              CORE_IN  = 2,
    parameter int              CORE_OUT = 2,
    parameter int              DW       = 16,
    parameter bit              UNIFORM  = 1'b0,
    parameter logic [MAXM-1:0] CONN     = mesh_matrix(LANES, CORE_IN, CORE_OUT),
    localparam int NLINK = 4 * LANES,
    localparam int NSRC  = NLINK + CORE_OUT,
    localparam int NSNK  = NLINK + CORE_IN,
    localparam int AW    = $clog2(NSNK),
    localparam int KAPPA = max_width(CONN, NSRC, NSNK),
    localparam int CW    = (KAPPA < 1) ? 1 : KAPPA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [CW-1:0]         cfg_wdata,
    input  logic [NLINK*DW-1:0]   link_in,
    input  logic [CORE_OUT*DW-1:0] core_out,
    output logic [NLINK*DW-1:0]   link_out,
    output logic [CORE_IN*DW-1:0] core_in
);

    logic [NSRC*DW-1:0] srcs;
    logic [NSNK*DW-1:0] sinks;

    assign srcs     = {core_out, link_in};
    assign link_out = sinks[NLINK*DW-1:0];
    assign core_in  = sinks[NSNK*DW-1 -: CORE_IN*DW];

    for (genvar j = 0; j < NSNK; j++) begin : g_sink
        localparam logic [MAXS-1:0] COL = column(CONN, NSRC, NSNK, j);
        localparam int CNT = popcnt(COL, NSRC);
        localparam int W   = sel_width(CNT);
        localparam int SW  = UNIFORM ? CW : W;

        if (CNT == 0) begin : g_idle
            assign sinks[j*DW +: DW] = '0;
        end else if (CNT == 1) begin : g_wire
            localparam int SRC = nth_driver(COL, NSRC, 0);
            assign sinks[j*DW +: DW] = srcs[SRC*DW +: DW];
        end else begin : g_mux
            logic [SW-1:0] sel;

            mxsw_sel_reg #(
                .SW (SW),
                .IDX(j),
                .AW (AW),
                .CW (CW)
            ) u_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_we   (cfg_we),
                .cfg_addr (cfg_addr),
                .cfg_wdata(cfg_wdata),
                .sel      (sel)
            );

            mxsw_sink_mux #(
                .NSRC(NSRC),
                .DW  (DW),
                .SW  (SW),
                .COL (COL)
            ) u_mux (
                .srcs(srcs),
                .sel (sel),
                .dout(sinks[j*DW +: DW])
            );
        end
    end

endmodule

// File: rtl/mxsw_switch_chk.sv
module mxsw_switch_chk
    import mxsw_pkg::*;
#(
    parameter int              LANES    = 2,
    parameter int              CORE_IN  = 2,
    parameter int              CORE_OUT = 2,
    parameter int              DW       = 16,
    parameter logic [MAXM-1:0] CONN     = mesh_matrix(LANES, CORE_IN, CORE_OUT),
    localparam int NLINK = 4 * LANES,
    localparam int NSRC  = NLINK + CORE_OUT,
    localparam int NSNK  = NLINK + CORE_IN,
    localparam int AW    = $clog2(NSNK)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [AW-1:0]          cfg_addr,
    input logic [NLINK*DW-1:0]    link_in,
    input logic [CORE_OUT*DW-1:0] core_out,
    input logic [NLINK*DW-1:0]    link_out,
    input logic [CORE_IN*DW-1:0]  core_in
);

    logic [NSRC*DW-1:0] srcs;
    logic [NSNK*DW-1:0] sinks;
    logic               armed_q;

    assign srcs  = {core_out, link_in};
    assign sinks = {core_in, link_out};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    for (genvar j = 0; j < NSNK; j++) begin : g_chk
        localparam logic [MAXS-1:0] COL = column(CONN, NSRC, NSNK, j);
        localparam int CNT = popcnt(COL, NSRC);
        logic [DW-1:0] sink;
        assign sink = sinks[j*DW +: DW];

        if (CNT == 0) begin : g_idle
            assert_idle_sink_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                sink == '0);
        end else if (CNT == 1) begin : g_wire
            localparam int SRC = nth_driver(COL, NSRC, 0);
            assert_single_driver_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
                sink == srcs[SRC*DW +: DW]);
        end else begin : g_mux
            localparam int FIRST = nth_driver(COL, NSRC, 0);
            logic legal;

            always_comb begin
                legal = (sink == '0);
                for (int i = 0; i < NSRC; i++)
                    if (COL[i] && (sink == srcs[i*DW +: DW])) legal = 1'b1;
            end

            assert_reset_lowest_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> sink == srcs[FIRST*DW +: DW]);

            assert_route_held_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && !$past(cfg_we && (cfg_addr == AW'(j))) && $stable(srcs))
                    |-> $stable(sink));

            assert_only_permitted_or_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                legal);
        end
    end

endmodule

bind mxsw_switch mxsw_switch_chk #(
    .LANES   (LANES),
    .CORE_IN (CORE_IN),
    .CORE_OUT(CORE_OUT),
    .DW      (DW),
    .CONN    (CONN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .link_in (link_in),
    .core_out(core_out),
    .link_out(link_out),
    .core_in (core_in)
);

// File: tb/mxsw_switch_tb.sv
`timescale 1ns/1ps
module mxsw_switch_tb;
    import mxsw_pkg::*;

    localparam int DW   = 8;
    localparam int NSNK = 6;
    localparam int AW   = 3;
    localparam int CW   = 3;

    function automatic logic [MAXM-1:0] bench_conn();
        logic [MAXM-1:0] m;
        m = '0;
        m[4*6+0] = 1'b1; m[5*6+0] = 1'b1;
        m[0*6+2] = 1'b1;
        m[1*6+3] = 1'b1; m[2*6+3] = 1'b1; m[4*6+3] = 1'b1;
        for (int i = 0; i < 6; i++) m[i*6+4] = 1'b1;
        m[3*6+5] = 1'b1; m[5*6+5] = 1'b1;
        return m;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [4*DW-1:0] link_in = '0;
    logic [2*DW-1:0] core_out = '0;
    logic [4*DW-1:0] lo_p, lo_u;
    logic [2*DW-1:0] ci_p, ci_u;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string ph = "R4";

    int drv [NSNK][$];
    int sel_p [NSNK];
    int sel_u [NSNK];

    always #2.5 clk = ~clk;

    mxsw_switch #(.LANES(1), .CORE_IN(2), .CORE_OUT(2), .DW(DW), .UNIFORM(1'b0),
                  .CONN(bench_conn())) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .link_in(link_in), .core_out(core_out),
        .link_out(lo_p), .core_in(ci_p));

    mxsw_switch #(.LANES(1), .CORE_IN(2), .CORE_OUT(2), .DW(DW), .UNIFORM(1'b1),
                  .CONN(bench_conn())) u_dut_uni (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .link_in(link_in), .core_out(core_out),
        .link_out(lo_u), .core_in(ci_u));

    function automatic int reg_width(int cnt);
        int w;
        w = 0;
        while ((1 << w) < cnt) w++;
        return w;
    endfunction

    function automatic int srcv(int i);
        return (i < 4) ? int'(link_in[i*DW +: DW]) : int'(core_out[(i-4)*DW +: DW]);
    endfunction

    function automatic int expv(int j, int sel);
        int cnt;
        cnt = drv[j].size();
        if (cnt == 0) return 0;
        if (cnt == 1) return srcv(drv[j][0]);
        if (sel >= cnt) return 0;
        return srcv(drv[j][sel]);
    endfunction

    function automatic int got(int uni, int j);
        if (uni == 0) return (j < 4) ? int'(lo_p[j*DW +: DW]) : int'(ci_p[(j-4)*DW +: DW]);
        return (j < 4) ? int'(lo_u[j*DW +: DW]) : int'(ci_u[(j-4)*DW +: DW]);
    endfunction

    // Reference register file: updated at each rising edge from the sampled write port.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NSNK; j++) begin
                sel_p[j] = 0;
                sel_u[j] = 0;
            end
        end else if (cfg_we && int'(cfg_addr) < NSNK && drv[int'(cfg_addr)].size() >= 2) begin
            sel_p[int'(cfg_addr)] = int'(cfg_wdata) & ((1 << reg_width(drv[int'(cfg_addr)].size())) - 1);
            sel_u[int'(cfg_addr)] = int'(cfg_wdata);
        end
    end

    task automatic check_all();
        for (int u = 0; u < 2; u++) begin
            for (int j = 0; j < NSNK; j++) begin
                int s;
                int e;
                int g;
                string tag;
                s = (u == 0) ? sel_p[j] : sel_u[j];
                e = expv(j, s);
                g = got(u, j);
                if (drv[j].size() == 0)                   tag = "R3";
                else if (drv[j].size() == 1)              tag = "R2";
                else if (s >= drv[j].size())              tag = "R8";
                else if (u == 1 && ph != "R4")            tag = "R7";
                else                                      tag = ph;
                total++;
                if (g != e) begin
                    bad++;
                    $display("FAIL %s dut=%0d sink=%0d got=%0h exp=%0h", tag, u, j, g, e);
                end
            end
        end
    endtask

    task automatic cyc(bit we, int addr, int data);
        @(negedge clk);
        cfg_we    = we;
        cfg_addr  = AW'(addr);
        cfg_wdata = CW'(data);
        link_in   = {$urandom, $urandom};
        core_out  = 16'($urandom);
        #1 check_all();
    endtask

    initial begin
        drv[0] = '{4, 5};
        drv[1] = '{};
        drv[2] = '{0};
        drv[3] = '{1, 2, 4};
        drv[4] = '{0, 1, 2, 3, 4, 5};
        drv[5] = '{3, 5};
        link_in  = {$urandom, $urandom};
        core_out = 16'($urandom);

        // R4: reset state, during and after reset
        repeat (3) cyc(0, 0, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) cyc(0, 0, 0);

        // R5: every select value into every sink, one at a time
        ph = "R5";
        for (int j = 0; j < NSNK; j++)
            for (int v = 0; v < 8; v++) begin
                cyc(1, j, v);
                cyc(0, 0, 0);
            end

        // R6: narrow registers keep only their low bits
        ph = "R6";
        cyc(1, 0, 6); cyc(0, 0, 0);
        cyc(1, 5, 7); cyc(0, 0, 0);
        cyc(1, 3, 5); cyc(0, 0, 0);

        // R9: writes to unregistered or absent sinks
        ph = "R9";
        cyc(1, 6, 1); cyc(1, 7, 2); cyc(1, 1, 3); cyc(1, 2, 1);
        cyc(0, 0, 0);

        // R10: sources change within a cycle, no edge in between
        ph = "R10";
        for (int n = 0; n < 6; n++) begin
            cyc(0, 0, 0);
            link_in  = {$urandom, $urandom};
            core_out = 16'($urandom);
            #0.5 check_all();
        end

        // R4: reset in mid-run clears a written configuration
        ph = "R4";
        cyc(1, 4, 5); cyc(1, 0, 1);
        @(negedge clk) rst_n = 1'b0;
        cyc(0, 0, 0);
        @(negedge clk) rst_n = 1'b1;
        cyc(0, 0, 0);

        // R1: random writes and sources
        ph = "R1";
        for (int n = 0; n < 200; n++)
            cyc(1'($urandom), int'($urandom % 8), int'($urandom % 8));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule